// File: doc/BRIEF.md
# Converter Sample Buffer with Interrupt Request

This block holds the 16-bit samples produced by an analog-to-digital conversion sequencer until a host collects them through a small register read port. Each sample carries its channel tag in the upper bits; the buffer stores the whole word unchanged and returns samples oldest first. Reading the data offset removes one sample. A status word, read at the control offset, shows whether the buffer is empty, at least half full or completely full. It also shows whether an interrupt request is pending, and carries a copy of the control byte.

The host selects one of two interrupt causes with the control byte. In the first, every stored sample raises the request. In the second, the request is raised once when the fill level climbs to half the depth, so the host can remove exactly half the buffer per interrupt. Two write-only strobe offsets let the host empty the buffer and drop the pending request. A full buffer is a fatal condition: a sample that arrives then is lost and a sticky error bit records the loss. The depth is a parameter, normally 1024 or 4096 words.

Top module: `adc_sample_fifo`

## Requirements
- R1: After reset the buffer is empty, the control byte is 0, no request is pending, `irq` is low and the status word reads 16'h0100.
- R2: Samples leave in arrival order. A read at offset 0 of a non-empty buffer returns the oldest sample on `rd_data` one cycle later and removes it.
- R3: The status word at offset 6 has bit 8 set when empty, bit 9 set when the level is at least DEPTH/2, bit 10 set when the level equals DEPTH, and bits 7:0 equal to the control byte last written at offset 6. Bits 15:13 read 0.
- R4: A sample that arrives while the buffer is full and no read removes a sample in the same cycle is discarded. It sets status bit 12, which stays set until the buffer is emptied by the flush strobe.
- R5: Any write at offset 9 empties the buffer and clears status bit 12. A sample arriving in that same cycle is not stored.
- R6: With control bit 4 = 1 and bit 5 = 0, every stored sample sets the pending request (status bit 11 and the `irq` pin).
- R7: With control bits 4 and 5 both 1, the request is set only when the level moves from below DEPTH/2 to DEPTH/2 or above. It is not set again until the level has dropped below DEPTH/2 and crossed upward again.
- R8: Any write at offset 8 clears the pending request. A set event in the same cycle wins, and the request stays set.
- R9: With control bit 4 = 0 no stored sample and no level crossing sets the request.
- R10: A read at offset 0 of an empty buffer returns the last sample removed and changes nothing. The next sample stored is the next one returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | A tagged sample is offered this cycle |
| smp_data | input | 16 | Tagged sample word |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_addr | input | 5 | Host write offset |
| host_wr_data | input | 16 | Host write data |
| host_rd_en | input | 1 | Host read strobe |
| host_rd_addr | input | 5 | Host read offset |
| host_rd_data | output | 16 | Read result, valid the cycle after the strobe |
| irq | output | 1 | Pending interrupt request |

## Verification
Every result here is due one clock edge after its stimulus. A sample offered at an edge changes the level, the status bits and the request at that same edge. A read strobe at an edge places its value on `host_rd_data` from that edge on. The bench drives all inputs on the falling edge and samples on the following falling edge, so each check sees exactly one rising edge between stimulus and observation. Level, overflow and request expectations are computed arithmetically from the number of samples pushed and removed.

// File: rtl/adc_fifo_pkg.sv
// Package: shared offsets, status bit positions and control bit positions
// for the converter sample buffer. Assumes a 16-bit host data path.
package adc_fifo_pkg;
    localparam int unsigned SMP_W        = 16;
    localparam int unsigned CTRL_W       = 8;
    // host offsets
    localparam int unsigned OFS_DATA     = 0;
    localparam int unsigned OFS_CTRL     = 6;
    localparam int unsigned OFS_IRQ_CLR  = 8;
    localparam int unsigned OFS_FLUSH    = 9;
    // status bit positions
    localparam int unsigned ST_EMPTY     = 8;
    localparam int unsigned ST_HALF      = 9;
    localparam int unsigned ST_FULL      = 10;
    localparam int unsigned ST_PENDING   = 11;
    localparam int unsigned ST_OVERRUN   = 12;
    // control bit positions
    localparam int unsigned CT_IRQ_EN    = 4;
    localparam int unsigned CT_HALF_MODE = 5;

    typedef struct packed {
        logic empty;
        logic half;
        logic full;
    } level_flags_t;
endpackage

// File: rtl/adc_fifo_store.sv
// Module: sample storage with read/write pointers and a level counter.
// Assumes DEPTH is a power of two and at least 4. Flush has priority over
// push and pop; a push into a full store is accepted only if a pop happens
// in the same cycle, otherwise it is dropped and the sticky overrun is set.
module adc_fifo_store #(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned DW    = 16,
    localparam int unsigned PW   = $clog2(DEPTH),
    localparam int unsigned CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic [DW-1:0] push_data,
    input  logic          pop_req,
    input  logic          flush,
    output logic [DW-1:0] head_data,
    output logic [CW-1:0] level,
    output logic [CW-1:0] level_nxt,
    output logic          push_done,
    output logic          overrun
);
    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic          do_pop;
    logic          do_push;
    logic          drop;

    // Decide which of push, pop and flush take effect this cycle.
    always_comb begin
        do_pop    = pop_req && (level != '0) && !flush;
        do_push   = push_req && !flush && ((level != FULL_LVL) || do_pop);
        drop      = push_req && !flush && !do_push;
        level_nxt = level;
        if (flush) begin
            level_nxt = '0;
        end else begin
            case ({do_push, do_pop})
                2'b10:   level_nxt = level + CW'(1);
                2'b01:   level_nxt = level - CW'(1);
                default: level_nxt = level;
            endcase
        end
    end

    assign push_done = do_push;
    assign head_data = mem[rd_ptr];

    // Sample memory write port, no reset needed.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Pointers, level and sticky overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            level   <= '0;
            overrun <= 1'b0;
        end else begin
            level <= level_nxt;
            if (flush) begin
                wr_ptr  <= '0;
                rd_ptr  <= '0;
                overrun <= 1'b0;
            end else begin
                if (do_push) wr_ptr <= wr_ptr + PW'(1);
                if (do_pop)  rd_ptr <= rd_ptr + PW'(1);
                if (drop)    overrun <= 1'b1;
            end
        end
    end

    // R3: the level never exceeds the depth.
    assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_LVL);

    // R4: a push into a full store without a pop leaves it full and flags overrun.
    assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && level == FULL_LVL && !pop_req && !flush)
        |=> (level == FULL_LVL && overrun));

    // R5: flush empties the store and clears overrun.
    assert_flush_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0 && !overrun));

    // R10: a pop from an empty store leaves the read pointer untouched.
    assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && level == '0 && !flush) |=> $stable(rd_ptr));
endmodule

// File: rtl/adc_fifo_irq.sv
// Module: interrupt request logic. Sets a pending flag either on every
// accepted sample or on an upward crossing of the half level, when enabled.
// A clear strobe drops the flag unless a set event occurs in the same cycle.
module adc_fifo_irq #(
    parameter int unsigned CW   = 11,
    parameter int unsigned HALF = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq_en,
    input  logic          half_mode,
    input  logic          push_done,
    input  logic [CW-1:0] level,
    input  logic [CW-1:0] level_nxt,
    input  logic          irq_clr,
    output logic          pending
);
    localparam logic [CW-1:0] HALF_LVL = CW'(HALF);

    logic crossing;
    logic set_evt;

    // Select the set event for the chosen interrupt cause.
    always_comb begin
        crossing = (level < HALF_LVL) && (level_nxt >= HALF_LVL);
        if (half_mode) set_evt = irq_en && crossing;
        else           set_evt = irq_en && push_done;
    end

    // Pending request register: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       pending <= 1'b0;
        else if (set_evt) pending <= 1'b1;
        else if (irq_clr) pending <= 1'b0;
    end

    // R8: a clear with no sample stored drops the request.
    assert_clear_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !push_done) |=> !pending);

    // R9: with interrupts disabled an idle request stays idle.
    assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en && !pending) |=> !pending);

    // R7: in half mode a new request only appears at or above the half level.
    assert_half_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (half_mode && !pending) |=> (!pending || level >= HALF_LVL));
endmodule

// File: rtl/adc_fifo_regs.sv
// Module: host register port. Holds the control byte, decodes the strobe
// offsets, builds the status word and registers the read result one cycle
// after the read strobe. Keeps the last popped sample for empty reads.
module adc_fifo_regs
    import adc_fifo_pkg::*;
#(
    parameter int unsigned AW = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [SMP_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    input  logic [SMP_W-1:0] head_data,
    input  level_flags_t     flags,
    input  logic             pending,
    input  logic             overrun,
    output logic             irq_en,
    output logic             half_mode,
    output logic             pop_req,
    output logic             flush,
    output logic             irq_clr,
    output logic [SMP_W-1:0] rd_data
);
    logic [CTRL_W-1:0] ctrl;
    logic [SMP_W-1:0]  last_pop;
    logic [SMP_W-1:0]  status_word;
    logic              ctrl_wr;

    // Decode host strobes.
    always_comb begin
        ctrl_wr = wr_en && (wr_addr == AW'(OFS_CTRL));
        flush   = wr_en && (wr_addr == AW'(OFS_FLUSH));
        irq_clr = wr_en && (wr_addr == AW'(OFS_IRQ_CLR));
        pop_req = rd_en && (rd_addr == AW'(OFS_DATA));
    end

    assign irq_en    = ctrl[CT_IRQ_EN];
    assign half_mode = ctrl[CT_HALF_MODE];

    // Assemble the status word from flags and the control byte.
    always_comb begin
        status_word                = '0;
        status_word[CTRL_W-1:0]    = ctrl;
        status_word[ST_EMPTY]      = flags.empty;
        status_word[ST_HALF]       = flags.half;
        status_word[ST_FULL]       = flags.full;
        status_word[ST_PENDING]    = pending;
        status_word[ST_OVERRUN]    = overrun;
    end

    // Control byte register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl <= '0;
        else if (ctrl_wr) ctrl <= wr_data[CTRL_W-1:0];
    end

    // Read result and last popped sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            last_pop <= '0;
        end else if (rd_en) begin
            if (rd_addr == AW'(OFS_DATA)) begin
                if (flags.empty) begin
                    rd_data <= last_pop;
                end else begin
                    rd_data  <= head_data;
                    last_pop <= head_data;
                end
            end else if (rd_addr == AW'(OFS_CTRL)) begin
                rd_data <= status_word;
            end else begin
                rd_data <= '0;
            end
        end
    end

    // R3: a control write is reflected in the stored control byte.
    assert_ctrl_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (ctrl == $past(wr_data[CTRL_W-1:0])));

    // R10: an empty data read returns the value kept from the last pop.
    assert_empty_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && flags.empty) |=> (rd_data == last_pop && $stable(last_pop)));
endmodule

// File: rtl/adc_sample_fifo.sv
// Module: top of the converter sample buffer. Connects storage, interrupt
// logic and host register port. Assumes DEPTH is a power of two, at least 4
// (1024 or 4096 in normal use). All outputs are registered.
module adc_sample_fifo
    import adc_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned AW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [15:0]      smp_data,
    input  logic             host_wr_en,
    input  logic [AW-1:0]    host_wr_addr,
    input  logic [15:0]      host_wr_data,
    input  logic             host_rd_en,
    input  logic [AW-1:0]    host_rd_addr,
    output logic [15:0]      host_rd_data,
    output logic             irq
);
    localparam int unsigned CW   = $clog2(DEPTH) + 1;
    localparam int unsigned HALF = DEPTH / 2;

    logic [SMP_W-1:0] head_data;
    logic [CW-1:0]    level;
    logic [CW-1:0]    level_nxt;
    logic             push_done;
    logic             overrun;
    logic             pending;
    logic             irq_en;
    logic             half_mode;
    logic             pop_req;
    logic             flush;
    logic             irq_clr;
    level_flags_t     flags;

    // Level flags derived from the counter.
    always_comb begin
        flags.empty = (level == '0);
        flags.half  = (level >= CW'(HALF));
        flags.full  = (level == CW'(DEPTH));
    end

    adc_fifo_store #(.DEPTH(DEPTH), .DW(SMP_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (smp_valid),
        .push_data (smp_data),
        .pop_req   (pop_req),
        .flush     (flush),
        .head_data (head_data),
        .level     (level),
        .level_nxt (level_nxt),
        .push_done (push_done),
        .overrun   (overrun)
    );

    adc_fifo_irq #(.CW(CW), .HALF(HALF)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_en    (irq_en),
        .half_mode (half_mode),
        .push_done (push_done),
        .level     (level),
        .level_nxt (level_nxt),
        .irq_clr   (irq_clr),
        .pending   (pending)
    );

    adc_fifo_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (host_wr_en),
        .wr_addr   (host_wr_addr),
        .wr_data   (host_wr_data),
        .rd_en     (host_rd_en),
        .rd_addr   (host_rd_addr),
        .head_data (head_data),
        .flags     (flags),
        .pending   (pending),
        .overrun   (overrun),
        .irq_en    (irq_en),
        .half_mode (half_mode),
        .pop_req   (pop_req),
        .flush     (flush),
        .irq_clr   (irq_clr),
        .rd_data   (host_rd_data)
    );

    assign irq = pending;

    // R1: out of reset the buffer is empty and no request is raised.
    assert_reset_state_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (level == '0 && !irq));

    // R6: in per-sample mode a stored sample always raises the request.
    assert_every_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_done && irq_en && !half_mode) |=> irq);
endmodule

// File: tb/adc_sample_fifo_tb.sv
module adc_sample_fifo_tb;
    localparam int DEPTH = 16;
    localparam int HALF  = DEPTH / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        host_wr_en = 1'b0;
    logic [4:0]  host_wr_addr = '0;
    logic [15:0] host_wr_data = '0;
    logic        host_rd_en = 1'b0;
    logic [4:0]  host_rd_addr = '0;
    logic [15:0] host_rd_data;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    adc_sample_fifo #(.DEPTH(DEPTH), .AW(5)) u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr),
        .host_wr_data(host_wr_data), .host_rd_en(host_rd_en),
        .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data), .irq(irq)
    );

    function automatic logic [15:0] smp(input int i);
        return 16'(((i % 16) << 12) | ((i * 37 + 5) & 12'hfff));
    endfunction

    function automatic logic [15:0] st(input int n, input logic [7:0] c,
                                       input bit pend, input bit ovf);
        logic [15:0] v;
        v = {8'h00, c};
        if (n == 0)     v[8]  = 1'b1;
        if (n >= HALF)  v[9]  = 1'b1;
        if (n == DEPTH) v[10] = 1'b1;
        v[11] = pend;
        v[12] = ovf;
        return v;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] v);
        @(negedge clk);
        smp_valid = 1'b1; smp_data = v;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_addr = 5'(a); host_wr_data = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] d);
        @(negedge clk);
        host_rd_en = 1'b1; host_rd_addr = 5'(a);
        @(negedge clk);
        host_rd_en = 1'b0;
        d = host_rd_data;
    endtask

    task automatic push_and_wr(input logic [15:0] v, input int a);
        @(negedge clk);
        smp_valid = 1'b1; smp_data = v;
        host_wr_en = 1'b1; host_wr_addr = 5'(a); host_wr_data = 16'h0;
        @(negedge clk);
        smp_valid = 1'b0; host_wr_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", {15'd0, irq}, 16'h0);
        rd(6, d); check("R1 status", d, 16'h0100);

        // R3 level flags while filling
        for (int i = 0; i < DEPTH; i++) begin
            push(smp(i));
            rd(6, d); check("R3 fill status", d, st(i + 1, 8'h00, 1'b0, 1'b0));
        end

        // R4 overrun on push into full buffer
        push(smp(99));
        rd(6, d); check("R4 overrun status", d, st(DEPTH, 8'h00, 1'b0, 1'b1));

        // R2 ordered drain, R4 sticky while draining
        for (int i = 0; i < DEPTH; i++) begin
            rd(0, d); check("R2 data order", d, smp(i));
            rd(6, d); check("R4 sticky status", d, st(DEPTH - 1 - i, 8'h00, 1'b0, 1'b1));
        end

        // R10 empty read returns last popped sample
        rd(0, d); check("R10 empty read", d, smp(DEPTH - 1));
        rd(6, d); check("R10 still empty", d, st(0, 8'h00, 1'b0, 1'b1));
        push(smp(40));
        rd(0, d); check("R10 next sample", d, smp(40));

        // R5 flush clears overrun and contents
        for (int i = 0; i < 5; i++) push(smp(60 + i));
        wr(9, 16'h0);
        rd(6, d); check("R5 flush status", d, st(0, 8'h00, 1'b0, 1'b0));
        push_and_wr(smp(70), 9);
        rd(6, d); check("R5 same-cycle sample dropped", d, st(0, 8'h00, 1'b0, 1'b0));
        push(smp(50));
        rd(0, d); check("R5 first after flush", d, smp(50));

        // R3 control readback, R9 disabled (bit5=1, bit4=0)
        wr(6, 16'h00A5);
        rd(6, d); check("R3 ctrl readback", d, st(0, 8'hA5, 1'b0, 1'b0));
        for (int i = 0; i < HALF + 1; i++) begin
            push(smp(i));
            check("R9 disabled irq", {15'd0, irq}, 16'h0);
        end
        wr(9, 16'h0);

        // R6 per-sample mode
        wr(6, 16'h0010);
        push(smp(1));
        check("R6 irq per sample", {15'd0, irq}, 16'h1);
        rd(6, d); check("R6 status pending", d, st(1, 8'h10, 1'b1, 1'b0));
        wr(8, 16'h0);
        check("R8 clear", {15'd0, irq}, 16'h0);
        push(smp(2));
        check("R6 irq second sample", {15'd0, irq}, 16'h1);
        push_and_wr(smp(3), 8);
        check("R8 set wins over clear", {15'd0, irq}, 16'h1);
        wr(8, 16'h0);
        check("R8 clear again", {15'd0, irq}, 16'h0);
        wr(9, 16'h0);

        // R7 half-level mode
        wr(6, 16'h0030);
        for (int i = 1; i < HALF; i++) begin
            push(smp(i));
            check("R7 below half", {15'd0, irq}, 16'h0);
        end
        push(smp(HALF));
        check("R7 crossing", {15'd0, irq}, 16'h1);
        wr(8, 16'h0);
        push(smp(HALF + 1));
        check("R7 no refire above half", {15'd0, irq}, 16'h0);
        rd(0, d); rd(0, d);
        check("R7 below half after pops", {15'd0, irq}, 16'h0);
        push(smp(HALF + 2));
        check("R7 second crossing", {15'd0, irq}, 16'h1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule